// File: doc/BRIEF.md
# Critical-Word-First Cache Line Refill Controller

This controller runs a single cache line refill after a miss. It accepts a miss as a line address and a word offset and issues one word request per cycle to the next memory level. Memory answers with a word-serial response stream that follows the request order. The controller writes every returning word into the data array at that word's own offset. It forwards the word the processor asked for in the same cycle that word arrives, so the processor can resume before the line is complete.

A mode input picks one of two orderings for each refill. In critical-word-first mode the missed word is requested first, and the order then wraps around the line. In early-restart mode the line is fetched from word 0 in ascending order, and the processor is released when the missed word goes by. A refill-done pulse marks the write of the last word, which is the moment the line may be marked valid. While the refill runs, a processor access to a word of the same line that has not arrived yet is stalled.

Top module: `cwf_refill`

## Requirements
- R1: After reset `busy`, `mem_req_valid`, `arr_we`, `cpu_data_valid`, `fill_done` and `cpu_stall` are all low.
- R2: With `mode_er` = 0 and miss offset k, the requested offsets are k, k+1, ..., WORDS-1, 0, ..., k-1, one per accepted request. Each request carries the miss line.
- R3: With `mode_er` = 1, the requested offsets are 0, 1, ..., WORDS-1 whatever the miss offset.
- R4: While `mem_req_valid` is high and `mem_req_ready` is low, the request offset and line hold. Exactly WORDS requests are issued per refill.
- R5: The n-th response (counting from 0) is written in its arrival cycle with `arr_we` = 1, `arr_off` = the n-th requested offset, `arr_data` = the response data and `arr_line` = the miss line.
- R6: `cpu_data_valid` is high in exactly one cycle per refill: the cycle the missed word arrives, with `cpu_data` equal to that word. This holds in both modes.
- R7: `fill_done` is high only in the cycle the last word of the line is written, and `busy` is low in the following cycle.
- R8: During a refill, `cpu_stall` is high when `cpu_rd_valid` is high, `cpu_rd_line` equals the miss line and the addressed word was not written in an earlier cycle. It is low otherwise.
- R9: A miss presented while `busy` is high is ignored: line, ordering and request count of the running refill are unchanged.
- R10: A cycle without `mem_rsp_valid` writes nothing and forwards nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| miss_valid | input | 1 | Start a refill (taken when idle) |
| miss_line | input | LINE_W | Line address of the miss |
| miss_off | input | OFF_W | Word offset that missed |
| mode_er | input | 1 | 1 = early restart, 0 = critical word first |
| busy | output | 1 | Refill in progress |
| mem_req_valid | output | 1 | Word request to memory |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_line | output | LINE_W | Requested line |
| mem_req_off | output | OFF_W | Requested word offset |
| mem_rsp_valid | input | 1 | Response word present |
| mem_rsp_data | input | DATA_W | Response word |
| arr_we | output | 1 | Data array write enable |
| arr_line | output | LINE_W | Data array line |
| arr_off | output | OFF_W | Data array word offset |
| arr_data | output | DATA_W | Data array write word |
| fill_done | output | 1 | Last word written; line may be marked valid |
| cpu_data_valid | output | 1 | Missed word forwarded |
| cpu_data | output | DATA_W | Forwarded word |
| cpu_rd_valid | input | 1 | Processor access during refill |
| cpu_rd_line | input | LINE_W | Line of that access |
| cpu_rd_off | input | OFF_W | Word of that access |
| cpu_stall | output | 1 | Access must wait for its word |

## Verification
The hardest case to reach is the stall decision in the middle of a refill. It depends on which words have landed so far, and that set differs between the two orderings and for every miss offset. The bench sweeps both modes against every offset of a four-word line. Between responses it probes the word that has just been written, the word that will arrive last, and an access to another line. It also holds the request ready low and presents a second miss mid-refill, to show that the running refill keeps its ordering.

// File: rtl/cwf_refill.sv
module cwf_refill #(
  parameter int WORDS  = 4,
  parameter int DATA_W = 32,
  parameter int LINE_W = 26,
  localparam int OFF_W = $clog2(WORDS),
  localparam int CNT_W = OFF_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              miss_valid,
  input  logic [LINE_W-1:0] miss_line,
  input  logic [OFF_W-1:0]  miss_off,
  input  logic              mode_er,
  output logic              busy,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [LINE_W-1:0] mem_req_line,
  output logic [OFF_W-1:0]  mem_req_off,
  input  logic              mem_rsp_valid,
  input  logic [DATA_W-1:0] mem_rsp_data,
  output logic              arr_we,
  output logic [LINE_W-1:0] arr_line,
  output logic [OFF_W-1:0]  arr_off,
  output logic [DATA_W-1:0] arr_data,
  output logic              fill_done,
  output logic              cpu_data_valid,
  output logic [DATA_W-1:0] cpu_data,
  input  logic              cpu_rd_valid,
  input  logic [LINE_W-1:0] cpu_rd_line,
  input  logic [OFF_W-1:0]  cpu_rd_off,
  output logic              cpu_stall
);
  logic              busy_q;
  logic [LINE_W-1:0] line_q;
  logic [OFF_W-1:0]  crit_q, start_q, rsp_cnt;
  logic [CNT_W-1:0]  req_cnt;
  logic [WORDS-1:0]  filled_q;

  wire accept   = miss_valid && !busy_q;
  wire req_fire = mem_req_valid && mem_req_ready;
  wire last     = rsp_cnt == OFF_W'(WORDS - 1);

  assign busy          = busy_q;
  assign mem_req_valid = busy_q && (req_cnt < CNT_W'(WORDS));
  assign mem_req_line  = line_q;
  assign mem_req_off   = start_q + req_cnt[OFF_W-1:0];

  assign arr_we    = busy_q && mem_rsp_valid;
  assign arr_line  = line_q;
  assign arr_off   = start_q + rsp_cnt;
  assign arr_data  = mem_rsp_data;
  assign fill_done = arr_we && last;

  assign cpu_data_valid = arr_we && (arr_off == crit_q);
  assign cpu_data       = mem_rsp_data;
  assign cpu_stall      = busy_q && cpu_rd_valid && (cpu_rd_line == line_q)
                          && !filled_q[cpu_rd_off];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q   <= 1'b0;
      line_q   <= '0;
      crit_q   <= '0;
      start_q  <= '0;
      req_cnt  <= '0;
      rsp_cnt  <= '0;
      filled_q <= '0;
    end else if (accept) begin
      busy_q   <= 1'b1;
      line_q   <= miss_line;
      crit_q   <= miss_off;
      start_q  <= mode_er ? '0 : miss_off;
      req_cnt  <= '0;
      rsp_cnt  <= '0;
      filled_q <= '0;
    end else begin
      if (req_fire) req_cnt <= req_cnt + 1'b1;
      if (arr_we) begin
        rsp_cnt           <= rsp_cnt + 1'b1;
        filled_q[arr_off] <= 1'b1;
        if (last) busy_q  <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/cwf_refill_chk.sv
module cwf_refill_chk #(
  parameter int LINE_W = 26,
  parameter int OFF_W  = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              mem_req_valid,
  input logic              mem_req_ready,
  input logic [OFF_W-1:0]  mem_req_off,
  input logic [LINE_W-1:0] mem_req_line,
  input logic              arr_we,
  input logic [LINE_W-1:0] arr_line,
  input logic              fill_done,
  input logic              cpu_data_valid,
  input logic              cpu_stall,
  input logic              mem_rsp_valid
);
  // R4
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_off) && $stable(mem_req_line));
  // R7
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fill_done |=> !busy);
  // R6
  fwd_in_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_data_valid |-> arr_we);
  // R10
  no_rsp_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_rsp_valid |-> !arr_we && !cpu_data_valid);
  // R9
  line_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy && $past(busy) |-> $stable(arr_line));
  // R8
  stall_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_stall |-> busy);
endmodule

bind cwf_refill cwf_refill_chk #(.LINE_W(LINE_W), .OFF_W(OFF_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .mem_req_valid(mem_req_valid),
  .mem_req_ready(mem_req_ready), .mem_req_off(mem_req_off),
  .mem_req_line(mem_req_line), .arr_we(arr_we), .arr_line(arr_line),
  .fill_done(fill_done), .cpu_data_valid(cpu_data_valid),
  .cpu_stall(cpu_stall), .mem_rsp_valid(mem_rsp_valid)
);

// File: tb/cwf_refill_tb.sv
module cwf_refill_tb;
  localparam int W = 4, DW = 16, LW = 8, OW = 2;
  logic clk = 0, rst_n = 0;
  logic miss_valid = 0, mode_er = 0, mem_req_ready = 0, mem_rsp_valid = 0;
  logic cpu_rd_valid = 0;
  logic [LW-1:0] miss_line = 0, cpu_rd_line = 0;
  logic [OW-1:0] miss_off = 0, cpu_rd_off = 0;
  logic [DW-1:0] mem_rsp_data = 0;
  logic busy, mem_req_valid, arr_we, fill_done, cpu_data_valid, cpu_stall;
  logic [LW-1:0] mem_req_line, arr_line;
  logic [OW-1:0] mem_req_off, arr_off;
  logic [DW-1:0] arr_data, cpu_data;
  int tests = 0, fails = 0;

  cwf_refill #(.WORDS(W), .DATA_W(DW), .LINE_W(LW)) u_dut (.*);

  always #5 clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int eoff(input bit er, input int k, input int i);
    return er ? i : (k + i) % W;
  endfunction

  task automatic refill(input bit er, input int k, input int ln);
    @(negedge clk);
    miss_valid = 1; miss_line = LW'(ln); miss_off = OW'(k); mode_er = er;
    @(negedge clk);
    miss_valid = 0;
    #1 chk(busy == 1, "R7 busy after miss", busy, 1);
    // request hold with ready low, plus ignored second miss (R9)
    mem_req_ready = 0; miss_valid = 1; miss_line = LW'(ln + 1); miss_off = OW'(k + 1);
    mode_er = !er;
    #1 chk(mem_req_valid && mem_req_off == OW'(eoff(er, k, 0)), "R4 first req",
           mem_req_off, eoff(er, k, 0));
    @(negedge clk);
    miss_valid = 0;
    #1 chk(mem_req_off == OW'(eoff(er, k, 0)) && mem_req_line == LW'(ln), "R4 hold",
           mem_req_off, eoff(er, k, 0));
    mem_req_ready = 1;
    for (int i = 0; i < W; i++) begin
      #1 chk(mem_req_valid && mem_req_off == OW'(eoff(er, k, i)),
             er ? "R3 req order" : "R2 req order", mem_req_off, eoff(er, k, i));
      chk(mem_req_line == LW'(ln), "R9 req line", mem_req_line, ln);
      @(negedge clk);
    end
    #1 chk(mem_req_valid == 0, "R4 count", mem_req_valid, 0);
    mem_req_ready = 0;
    for (int i = 0; i < W; i++) begin
      int o = eoff(er, k, i);
      mem_rsp_valid = 0;
      #1 chk(!arr_we && !cpu_data_valid, "R10 idle rsp", arr_we, 0);
      if (i > 0) begin
        int pv = eoff(er, k, i - 1);
        int lst = eoff(er, k, W - 1);
        cpu_rd_valid = 1; cpu_rd_line = LW'(ln);
        cpu_rd_off = OW'(pv);
        #1 chk(cpu_stall == 0, "R8 filled no stall", cpu_stall, 0);
        cpu_rd_off = OW'(lst);
        #1 chk(cpu_stall == 1, "R8 unfilled stall", cpu_stall, 1);
        cpu_rd_line = LW'(ln + 3);
        #1 chk(cpu_stall == 0, "R8 other line", cpu_stall, 0);
        cpu_rd_valid = 0;
      end
      @(negedge clk);
      mem_rsp_valid = 1; mem_rsp_data = DW'(ln * 16 + o * 3 + 1);
      #1 chk(arr_we && arr_off == OW'(o) && arr_line == LW'(ln) && arr_data == mem_rsp_data,
             "R5 write", arr_off, o);
      chk(cpu_data_valid == (o == k), "R6 forward", cpu_data_valid, o == k);
      if (o == k) chk(cpu_data == mem_rsp_data, "R6 data", cpu_data, mem_rsp_data);
      chk(fill_done == (i == W - 1), "R7 done pulse", fill_done, i == W - 1);
      @(negedge clk);
    end
    mem_rsp_valid = 0;
    #1 chk(busy == 0 && fill_done == 0, "R7 idle after done", busy, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #1 chk(!busy && !mem_req_valid && !arr_we && !cpu_data_valid && !fill_done && !cpu_stall,
           "R1 reset", busy, 0);
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1 chk(!busy && !mem_req_valid && !arr_we && !cpu_stall, "R1 idle", busy, 0);
    for (int m = 0; m < 2; m++)
      for (int k = 0; k < W; k++)
        refill(m[0], k, 16 + m * 8 + k * 2);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule